// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes received Ethernet frames as a byte stream (valid, start and end markers) and stores them in a circular buffer in memory. The buffer is divided into 32-byte lines, and every offset the block keeps or publishes counts whole lines. Line 0 is not used for frame data. The block keeps the newest published write offset in the low two bytes of line 0, so software can poll memory instead of reading a register. Each stored frame starts with a two-byte length field, low byte first. The frame bytes follow that field directly. A frame that runs past the last line continues at line 1, and no second length field is written there.

Software owns a read-offset register. It writes the index of the last line it has consumed, and that returns space to the ring. The block never writes a frame into the line named by the read offset. It raises a level interrupt while unread data is present, unless the mask input is set. Frames are written speculatively while their bytes arrive. A frame that turns out to be too short, too long, or too big for the free space is dropped without being published. When a frame is dropped, the write offset does not move and a drop counter counts up.

After the end byte of a frame, the source must stay idle for at least three cycles. In that time the block finishes the frame: it writes the last line, then the first line with its length field, then the mirror word.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset the write offset is 0, the drop count is 0, the interrupt is low and no memory write is issued.
- R2: A frame of L bytes is stored in ceil((L+2)/32) consecutive lines, starting at the line after the current write offset. Bytes 0 and 1 of the first line hold L, low byte first. Frame byte i sits at ring byte i+2. A line index n is written to address cfg_base + n.
- R3: Every line except the last of a frame is written with all 32 byte enables set. The last line enables only its occupied bytes, and its unoccupied bytes are zero. Lines in the middle are written as they fill. Then come the last line, the first line and the mirror, in that order.
- R4: The line after cfg_max is line 1, never line 0. When a frame wraps, its remaining bytes continue at the start of line 1, and the write offset ends at ceil(remaining/32).
- R5: When a frame is accepted, wr_offset becomes the index of the last line the frame used. The next frame starts at wr_offset+1.
- R6: Each update of the write offset comes with a write to line 0. That write has byte enables 0x3 and carries the new offset in data bits 15:0. It appears in the same cycle as the new wr_offset.
- R7: A frame shorter than 20 bytes or longer than 1536 bytes is dropped. A dropped frame gets no length field and no mirror write, wr_offset stays the same, and drop_count increases by exactly 1. Lengths of exactly 20 and exactly 1536 are accepted.
- R8: A frame that would use the line equal to the read offset is dropped in the same way as in R7. Its first line counts in this check. No write goes to that line, and the next frame starts where the dropped one would have started.
- R9: irq is high exactly when wr_offset differs from the read offset and irq_mask is low. The read offset is loaded from rd_val when rd_we is high.
- R10: Bytes that arrive outside a frame are ignored, that is, with no start marker since the last end marker or reset. They cause no memory write and no change of offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A byte is present on rx_byte |
| rx_sof | input | 1 | This byte is the first byte of a frame |
| rx_eof | input | 1 | This byte is the last byte of a frame |
| rx_byte | input | 8 | Frame byte |
| cfg_base | input | ADDR_W | Ring base address, in line units (byte address divided by 32) |
| cfg_max | input | OFF_W | Highest line index of the ring |
| rd_we | input | 1 | Load the read offset |
| rd_val | input | OFF_W | New read offset (last line consumed) |
| irq_mask | input | 1 | Suppress the interrupt |
| mem_we | output | 1 | Line write strobe |
| mem_addr | output | ADDR_W | Line address of the write |
| mem_data | output | 256 | Line data, byte k at bits 8k+7:8k |
| mem_be | output | 32 | Byte enables, bit k for byte k |
| wr_offset | output | OFF_W | Published write offset |
| irq | output | 1 | Interrupt request |
| drop_count | output | CNT_W | Number of frames dropped |

## Verification
A wrong line index, byte position or byte enable shows up as a mismatch on the memory port, at the same write that carries it. A frame written at the wrong position is already visible when its first middle line fills. A wrong first-line start only shows up when the length field is written, three cycles after the end byte. An error in the space check or the length window shows up in one of three ways: a write where none is expected, a missing length or mirror write, or a drop count that is off once the frame has finished. A wrong stored write offset goes unseen until the next frame is placed. A wrong read offset shows up on irq one cycle after the register write.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RECV = 3'd1,
        S_LAST = 3'd2,
        S_HEAD = 3'd3,
        S_MIRR = 3'd4
    } rxr_state_e;
endpackage

// File: rtl/rxr_wrap_step.sv
`timescale 1ns/1ps
// Next ring line after cur; index 0 is skipped, past max_line goes back to 1.
module rxr_wrap_step #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] cur,
    input  logic [OFF_W-1:0] max_line,
    output logic [OFF_W-1:0] nxt
);
    assign nxt = (cur >= max_line) ? OFF_W'(1) : cur + OFF_W'(1);
endmodule

// File: rtl/rxr_lane_insert.sv
`timescale 1ns/1ps
// Places one byte into a line image at byte lane pos; clear zeroes the other lanes.
module rxr_lane_insert #(
    parameter int LINE_BYTES = 32,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int POS_W = $clog2(LINE_BYTES + 1)
) (
    input  logic [LINE_W-1:0] line_in,
    input  logic              clear,
    input  logic [POS_W-1:0]  pos,
    input  logic [7:0]        byte_in,
    output logic [LINE_W-1:0] line_out
);
    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
        assign line_out[8*k +: 8] = (pos == POS_W'(k)) ? byte_in :
                                    (clear ? 8'h00 : line_in[8*k +: 8]);
    end
endmodule

// File: rtl/rxr_be_mask.sv
`timescale 1ns/1ps
// Byte-enable mask with the lowest count lanes set.
module rxr_be_mask #(
    parameter int LINE_BYTES = 32,
    localparam int POS_W = $clog2(LINE_BYTES + 1)
) (
    input  logic [POS_W-1:0]      count,
    output logic [LINE_BYTES-1:0] mask
);
    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_bit
        assign mask[k] = (count > POS_W'(k));
    end
endmodule

// File: rtl/rxr_ring_writer.sv
`timescale 1ns/1ps
module rxr_ring_writer #(
    parameter int LINE_BYTES = 32,
    parameter int OFF_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int MIN_LEN    = 20,
    parameter int MAX_LEN    = 1536,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int POS_W     = $clog2(LINE_BYTES + 1),
    localparam int HDR_B     = 2,
    localparam int HDR_W     = HDR_B * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic                  rx_eof,
    input  logic [7:0]            rx_byte,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [OFF_W-1:0]      cfg_max,
    input  logic                  rd_we,
    input  logic [OFF_W-1:0]      rd_val,
    input  logic                  irq_mask,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_data,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic [OFF_W-1:0]      wr_offset,
    output logic                  irq,
    output logic [CNT_W-1:0]      drop_count
);
    import rxr_pkg::*;

    typedef struct packed {
        rxr_state_e            st;
        logic [OFF_W-1:0]      wr;
        logic [OFF_W-1:0]      rd;
        logic [OFF_W-1:0]      start;
        logic [OFF_W-1:0]      cur;
        logic [POS_W-1:0]      pos;
        logic [HDR_W-1:0]      len;
        logic                  ovf;
        logic [LINE_W-1:0]     lbuf;
        logic [LINE_W-1:0]     fbuf;
        logic [CNT_W-1:0]      drops;
        logic                  we;
        logic [OFF_W-1:0]      wline;
        logic [LINE_W-1:0]     wdata;
        logic [LINE_BYTES-1:0] wbe;
    } ring_state_t;

    ring_state_t q, d;

    logic [OFF_W-1:0]      start_nx, cur_nx;
    logic [LINE_W-1:0]     ins_line;
    logic [LINE_BYTES-1:0] pos_mask;
    logic                  take, flush, ins_clear, drop_now;
    logic [POS_W-1:0]      ins_pos;

    assign take  = rx_valid && ((rx_sof && (q.st == S_IDLE || q.st == S_RECV)) || q.st == S_RECV);
    assign flush = (q.st == S_RECV) && !rx_sof && (q.pos == POS_W'(LINE_BYTES));
    assign ins_clear = rx_sof || flush;
    assign ins_pos   = rx_sof ? POS_W'(HDR_B) : (flush ? '0 : q.pos);

    rxr_wrap_step #(.OFF_W(OFF_W)) u_start_step (.cur(q.wr),  .max_line(cfg_max), .nxt(start_nx));
    rxr_wrap_step #(.OFF_W(OFF_W)) u_cur_step   (.cur(q.cur), .max_line(cfg_max), .nxt(cur_nx));

    rxr_lane_insert #(.LINE_BYTES(LINE_BYTES)) u_insert (
        .line_in(q.lbuf), .clear(ins_clear), .pos(ins_pos),
        .byte_in(rx_byte), .line_out(ins_line)
    );

    rxr_be_mask #(.LINE_BYTES(LINE_BYTES)) u_mask (.count(q.pos), .mask(pos_mask));

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.wline  = '0;
        d.wdata  = '0;
        d.wbe    = '0;
        drop_now = 1'b0;
        if (rd_we) d.rd = rd_val;

        if (take) begin
            if (rx_sof) begin
                d.start = start_nx;
                d.cur   = start_nx;
                d.ovf   = (start_nx == q.rd);
                d.len   = HDR_W'(1);
                d.pos   = POS_W'(HDR_B + 1);
            end else begin
                if (q.len <= HDR_W'(MAX_LEN)) d.len = q.len + 1'b1;
                if (flush) begin
                    if (q.cur == q.start) begin
                        d.fbuf = q.lbuf;
                    end else if (!q.ovf) begin
                        d.we    = 1'b1;
                        d.wline = q.cur;
                        d.wdata = q.lbuf;
                        d.wbe   = '1;
                    end
                    d.cur = cur_nx;
                    d.ovf = q.ovf || (cur_nx == q.rd);
                    d.pos = POS_W'(1);
                end else begin
                    d.pos = q.pos + 1'b1;
                end
            end
            d.lbuf = ins_line;
            d.st   = S_RECV;
            if (rx_eof) begin
                drop_now = d.ovf || (d.len < HDR_W'(MIN_LEN)) || (d.len > HDR_W'(MAX_LEN));
                if (drop_now) begin
                    d.st    = S_IDLE;
                    d.drops = q.drops + 1'b1;
                end else begin
                    d.st = (d.cur != d.start) ? S_LAST : S_HEAD;
                end
            end
        end else begin
            case (q.st)
                S_LAST: begin
                    d.we    = 1'b1;
                    d.wline = q.cur;
                    d.wdata = q.lbuf;
                    d.wbe   = pos_mask;
                    d.st    = S_HEAD;
                end
                S_HEAD: begin
                    d.we    = 1'b1;
                    d.wline = q.start;
                    if (q.cur == q.start) begin
                        d.wdata = {q.lbuf[LINE_W-1:HDR_W], q.len};
                        d.wbe   = pos_mask;
                    end else begin
                        d.wdata = {q.fbuf[LINE_W-1:HDR_W], q.len};
                        d.wbe   = '1;
                    end
                    d.st = S_MIRR;
                end
                S_MIRR: begin
                    d.we    = 1'b1;
                    d.wline = '0;
                    d.wdata = LINE_W'(q.cur);
                    d.wbe   = LINE_BYTES'(3);
                    d.wr    = q.cur;
                    d.st    = S_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we     = q.we;
    assign mem_addr   = cfg_base + ADDR_W'(q.wline);
    assign mem_data   = q.wdata;
    assign mem_be     = q.wbe;
    assign wr_offset  = q.wr;
    assign drop_count = q.drops;
    assign irq        = (q.wr != q.rd) && !irq_mask;
endmodule

// File: rtl/rxr_ring_writer_chk.sv
`timescale 1ns/1ps
module rxr_ring_writer_chk #(
    parameter int LINE_BYTES = 32,
    parameter int OFF_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     cfg_base,
    input logic [OFF_W-1:0]      cfg_max,
    input logic                  irq_mask,
    input logic                  mem_we,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [OFF_W-1:0]      mirror_word,
    input logic [LINE_BYTES-1:0] mem_be,
    input logic [OFF_W-1:0]      wr_offset,
    input logic                  irq,
    input logic [CNT_W-1:0]      drop_count
);
    // R6
    mirror_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_addr == cfg_base) |-> (mem_be == LINE_BYTES'(3)));

    // R6
    mirror_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_offset != $past(wr_offset)) |->
        (mem_we && mem_addr == cfg_base && mirror_word == wr_offset));

    // R4
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_offset != $past(wr_offset)) |-> (wr_offset != '0 && wr_offset <= cfg_max));

    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
        (drop_count == $past(drop_count) + 1'b1 && wr_offset == $past(wr_offset)));

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr - cfg_base) <= ADDR_W'(cfg_max)));

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(
    .LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_max(cfg_max),
    .irq_mask(irq_mask), .mem_we(mem_we), .mem_addr(mem_addr),
    .mirror_word(mem_data[OFF_W-1:0]), .mem_be(mem_be),
    .wr_offset(wr_offset), .irq(irq), .drop_count(drop_count)
);

// File: tb/rxr_ring_writer_test.sv
`timescale 1ns/1ps
module rxr_ring_writer_test;
    localparam int AW = 32;
    localparam int OW = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, rx_valid, rx_sof, rx_eof, rd_we, irq_mask;
    logic [7:0] rx_byte;
    logic [AW-1:0] cfg_base;
    logic [OW-1:0] cfg_max, rd_val;
    logic mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [255:0] mem_data;
    logic [31:0] mem_be;
    logic [OW-1:0] wr_offset;
    logic [15:0] drop_count;

    rxr_ring_writer uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_byte(rx_byte), .cfg_base(cfg_base), .cfg_max(cfg_max), .rd_we(rd_we),
        .rd_val(rd_val), .irq_mask(irq_mask), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .wr_offset(wr_offset), .irq(irq),
        .drop_count(drop_count)
    );

    typedef struct {
        logic [AW-1:0]  a;
        logic [255:0]   d;
        logic [31:0]    be;
        string          req;
    } exp_wr_t;

    exp_wr_t expq[$];
    int checks = 0;
    int errors = 0;
    int exp_wr = 0;
    int exp_rd = 0;
    int exp_drops = 0;
    int maxl = 63;
    logic [7:0] img [0:1700];

    function automatic int nxt(int c);
        return (c >= maxl) ? 1 : c + 1;
    endfunction

    function automatic logic [255:0] line_img(int k, int cnt);
        logic [255:0] r = '0;
        for (int j = 0; j < cnt; j++) r[8*j +: 8] = img[32*k + j];
        return r;
    endfunction

    function automatic logic [31:0] be_of(int cnt);
        logic [31:0] r = '0;
        for (int j = 0; j < cnt; j++) r[j] = 1'b1;
        return r;
    endfunction

    task automatic push(int line, logic [255:0] dat, logic [31:0] be, string req);
        exp_wr_t e;
        e.a = cfg_base + AW'(line);
        e.d = dat;
        e.be = be;
        e.req = req;
        expq.push_back(e);
    endtask

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compares every memory write against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            exp_wr_t e;
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected write actual addr %h be %h expected none",
                         mem_addr, mem_be);
            end else begin
                e = expq.pop_front();
                if (mem_addr !== e.a || mem_data !== e.d || mem_be !== e.be) begin
                    errors++;
                    $display("FAIL %s write actual addr %h be %h data %h expected addr %h be %h data %h",
                             e.req, mem_addr, mem_be, mem_data, e.a, e.be, e.d);
                end
            end
        end
    end

    task automatic set_rd(int v);
        @(negedge clk);
        rd_we = 1'b1;
        rd_val = OW'(v);
        @(negedge clk);
        rd_we = 1'b0;
        exp_rd = v;
        @(negedge clk);
    endtask

    // Driver: predicts the writes of one frame, then drives its bytes.
    task automatic send_frame(int len, int seed, string req);
        int n, start, line, prev, last, cnt_last;
        bit ovf, drop;
        img[0] = len[7:0];
        img[1] = len[15:8];
        for (int i = 0; i < len; i++) img[2 + i] = 8'(seed + i * 7);
        n = (len + 2 + 31) / 32;
        start = nxt(exp_wr);
        line = start;
        ovf = (start == exp_rd);
        for (int k = 1; k < n; k++) begin
            prev = line;
            line = nxt(line);
            if (k - 1 >= 1 && !ovf) push(prev, line_img(k - 1, 32), '1, req);
            if (line == exp_rd) ovf = 1'b1;
        end
        drop = ovf || len < 20 || len > 1536;
        if (drop) begin
            exp_drops++;
        end else begin
            last = line;
            cnt_last = (len + 2) - 32 * (n - 1);
            if (n > 1) begin
                push(last, line_img(n - 1, cnt_last), be_of(cnt_last), req);
                push(start, line_img(0, 32), '1, req);
            end else begin
                push(start, line_img(0, len + 2), be_of(len + 2), req);
            end
            push(0, 256'(last), 32'h3, "R6");
            exp_wr = last;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == len - 1);
            rx_byte = img[2 + i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof = 1'b0;
        rx_eof = 1'b0;
        repeat (6) @(negedge clk);
        check(expq.size() == 0, req, "pending writes", expq.size(), 0);
        check(wr_offset == OW'(exp_wr), "R5", "wr_offset", wr_offset, exp_wr);
        check(drop_count == 16'(exp_drops), "R7", "drop_count", drop_count, exp_drops);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_byte = '0;
        rd_we = 1'b0; rd_val = '0; irq_mask = 1'b0;
        cfg_base = 32'h0004_0000;
        cfg_max = OW'(maxl);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(wr_offset == 0, "R1", "wr_offset", wr_offset, 0);
        check(drop_count == 0, "R1", "drop_count", drop_count, 0);
        check(irq == 0, "R1", "irq", irq, 0);
        check(mem_we == 0, "R1", "mem_we", mem_we, 0);

        // R2 smallest legal frame, single line
        send_frame(20, 8'h11, "R2");
        check(irq == 1, "R9", "irq with unread data", irq, 1);
        irq_mask = 1'b1;
        @(negedge clk);
        check(irq == 0, "R9", "irq masked", irq, 0);
        irq_mask = 1'b0;
        set_rd(exp_wr);
        check(irq == 0, "R9", "irq after read offset catch-up", irq, 0);

        send_frame(64, 8'h20, "R2");
        set_rd(exp_wr);
        send_frame(30, 8'h35, "R3");
        set_rd(exp_wr);
        send_frame(31, 8'h41, "R3");
        set_rd(exp_wr);
        send_frame(19, 8'h50, "R7");
        send_frame(1537, 8'h60, "R7");
        send_frame(1536, 8'h71, "R7");
        set_rd(exp_wr);
        send_frame(100, 8'h82, "R3");
        set_rd(exp_wr);
        send_frame(200, 8'h93, "R4");
        check(wr_offset == 4, "R4", "wr_offset after wrap", wr_offset, 4);
        set_rd(exp_wr);

        // R10 bytes outside a frame
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = 1'b0;
            rx_eof = (i == 39);
            rx_byte = 8'(i);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_eof = 1'b0;
        repeat (6) @(negedge clk);
        check(wr_offset == OW'(exp_wr), "R10", "wr_offset after stray bytes", wr_offset, exp_wr);
        check(drop_count == 16'(exp_drops), "R10", "drop_count after stray bytes", drop_count, exp_drops);

        // R8 first line would be the read-offset line
        set_rd(nxt(exp_wr));
        send_frame(20, 8'hA4, "R8");
        // R8 frame runs into the read-offset line partway through
        set_rd(exp_wr + 10);
        send_frame(400, 8'hB5, "R8");
        set_rd(exp_wr);
        send_frame(40, 8'hC6, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule